// File: doc/BRIEF.md
# Compressed Elapsed Cycle Counter

This block measures how many active cycles pass between two consecutive entries of a transfer-record buffer and hands the record a 16-bit compressed form of that count, plus a flag saying whether the count can be trusted. A cycle is active when the `active_i` enable is high, which the surrounding logic drives while the current privilege mode is enabled for recording and recording is not frozen. The count is held in a saturating binary counter whose width follows from the exponent width parameter `CCE_W` (0 to 4): 11 + 2^CCE_W bits, that is 12, 13, 15, 19 or 27 bits.

The compression behaves like a small floating-point format. Counts below 4096 are reported exactly, with a zero exponent. Larger counts report the position of the leading one as an exponent (index minus 11) and keep the twelve bits that follow the leading one as the mantissa, the leading one itself being implied. The `record_i` strobe marks the cycle in which an entry is written. The fields are valid in that same cycle, and the counter opens a new interval there. The `clear_i` pulse, raised by a control-register write or a clear command, discards the running count and marks the next emitted count invalid. The fields are meaningful only in a strobe cycle. The block has no ready signal and applies no back-pressure, because a record is never stalled: the consumer must latch the fields in the strobe cycle.

Top module: `elapsed_cc`

## Requirements
- R1: While neither `record_i` nor `clear_i` is high, the count rises by one at each clock edge where `active_i` is high and is unchanged where `active_i` is low.
- R2: For a count below 4096, `cce_o` is 0 and `ccm_o` equals the count.
- R3: For a count of 4096 or more whose most significant one sits at bit index p, `cce_o` equals p-11 and `ccm_o` holds count bits [p-1 : p-12].
- R4: The counter is 11 + 2^CCE_W bits wide and saturates at all ones. The fields then read `ccm_o` = 4095 and `cce_o` = 2^CCE_W-1, and they stay there while further active cycles arrive.
- R5: `cce_o` is 4 bits wide. Its bits at index CCE_W and above always read 0, so `cce_o` never exceeds 2^CCE_W-1.
- R6: In a cycle with `record_i` high, the fields encode the count accumulated before that cycle. After that edge the count is 1 if `active_i` was high in the record cycle, and 0 otherwise.
- R7: A cycle with `clear_i` high leaves the count at 0 after its edge. This holds whatever `active_i` and `record_i` are in that cycle.
- R8: `ccv_o` is 0 after reset and after any `clear_i` cycle. It becomes 1 after a `record_i` cycle without `clear_i`, and it stays 1 until the next `clear_i`.
- R9: While `rst_ni` is low, the count is 0 and `ccv_o` is 0, so `ccm_o` and `cce_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| active_i | input | 1 | Recording is active in this cycle (count enable) |
| record_i | input | 1 | An entry is written this cycle; fields are sampled now |
| clear_i | input | 1 | Control write or clear command: restart the count, invalidate it |
| ccm_o | output | 12 | Cycle count mantissa |
| cce_o | output | 4 | Cycle count exponent; bits CCE_W and above are 0 |
| ccv_o | output | 1 | Cycle count valid |

## Verification
All three outputs are combinational functions of registered state. The fields therefore show the effect of a strobe, clear or active cycle exactly one clock edge later, and in a record cycle they show the count accumulated up to the edge before it. The bench drives inputs on the falling edge and compares all outputs against a behavioural model a few nanoseconds later, while the inputs are still stable. It then advances the model at the following rising edge, so every cycle is checked at the one edge where its result is due. The runs to 4096, to mid-range exponents and to saturation are checked in every cycle as well, so an off-by-one at a boundary shows up in the exact cycle where it occurs.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int unsigned MANT_W = 12;
  localparam int unsigned EXP_PORT_W = 4;

  function automatic int unsigned cnt_width(int unsigned exp_w);
    return 11 + (1 << exp_w);
  endfunction
endpackage

// File: rtl/cc_count.sv
module cc_count #(
  parameter int unsigned CNT_W = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             record_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_max;

  assign at_max = &cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i) begin
      cnt_d = '0;
    end else if (record_i) begin
      cnt_d = {{(CNT_W-1){1'b0}}, active_i};
    end else if (active_i && !at_max) begin
      cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cc_encode.sv
module cc_encode
  import cc_pkg::*;
#(
  parameter int unsigned CCE_W = 3,
  parameter int unsigned CNT_W = 19
) (
  input  logic [CNT_W-1:0]      cnt_i,
  output logic [MANT_W-1:0]     ccm_o,
  output logic [EXP_PORT_W-1:0] cce_o
);
  logic [EXP_PORT_W-1:0] expo;
  logic [EXP_PORT_W-1:0] shamt;
  logic [CNT_W-1:0]      shifted;

  generate
    if (CNT_W > MANT_W) begin : g_search
      always_comb begin
        expo = '0;
        for (int i = MANT_W; i < CNT_W; i++) begin
          if (cnt_i[i]) expo = EXP_PORT_W'(i - (MANT_W - 1));
        end
      end
    end else begin : g_flat
      assign expo = '0;
    end
  endgenerate

  assign shamt   = expo - {{(EXP_PORT_W-1){1'b0}}, 1'b1};
  assign shifted = cnt_i >> shamt;

  assign ccm_o = (expo == '0) ? cnt_i[MANT_W-1:0] : shifted[MANT_W-1:0];
  assign cce_o = expo;
endmodule

// File: rtl/cc_vflag.sv
module cc_vflag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic record_i,
  input  logic clear_i,
  output logic ccv_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       armed_q <= 1'b0;
    else if (clear_i)  armed_q <= 1'b0;
    else if (record_i) armed_q <= 1'b1;
  end

  assign ccv_o = armed_q;
endmodule

// File: rtl/elapsed_cc.sv
module elapsed_cc
  import cc_pkg::*;
#(
  parameter int unsigned CCE_W = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  active_i,
  input  logic                  record_i,
  input  logic                  clear_i,
  output logic [MANT_W-1:0]     ccm_o,
  output logic [EXP_PORT_W-1:0] cce_o,
  output logic                  ccv_o
);
  localparam int unsigned CNT_W = cnt_width(CCE_W);

  logic [CNT_W-1:0] cnt;

  cc_count #(.CNT_W(CNT_W)) u_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active_i),
    .record_i (record_i),
    .clear_i  (clear_i),
    .cnt_o    (cnt)
  );

  cc_encode #(.CCE_W(CCE_W), .CNT_W(CNT_W)) u_encode (
    .cnt_i (cnt),
    .ccm_o (ccm_o),
    .cce_o (cce_o)
  );

  cc_vflag u_vflag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .record_i (record_i),
    .clear_i  (clear_i),
    .ccv_o    (ccv_o)
  );
endmodule

// File: rtl/cc_check.sv
module cc_check #(
  parameter int unsigned CCE_W = 3
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        active_i,
  input logic        record_i,
  input logic        clear_i,
  input logic [11:0] ccm_o,
  input logic [3:0]  cce_o,
  input logic        ccv_o
);
  localparam logic [3:0] CCE_MAX = 4'((1 << CCE_W) - 1);

  a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !record_i && !clear_i && cce_o == 4'd0 && ccm_o != 12'hFFF)
      |=> (cce_o == 4'd0 && ccm_o == $past(ccm_o) + 12'd1));

  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && !record_i && !clear_i) |=> ($stable(ccm_o) && $stable(cce_o)));

  a_r4_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ccm_o == 12'hFFF && cce_o == CCE_MAX && !record_i && !clear_i)
      |=> ($stable(ccm_o) && $stable(cce_o)));

  a_r5_exp_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cce_o <= CCE_MAX);

  a_r6_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (record_i && !clear_i) |=> (cce_o == 4'd0 && ccm_o == {11'd0, $past(active_i)}));

  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (ccm_o == 12'd0 && cce_o == 4'd0));

  a_r8_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !ccv_o);

  a_r8_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (record_i && !clear_i) |=> ccv_o);

  a_r8_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ccv_o && !clear_i) |=> ccv_o);
endmodule

bind elapsed_cc cc_check #(.CCE_W(CCE_W)) u_check (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .active_i (active_i),
  .record_i (record_i),
  .clear_i  (clear_i),
  .ccm_o    (ccm_o),
  .cce_o    (cce_o),
  .ccv_o    (ccv_o)
);

// File: tb/elapsed_cc_tb.sv
module elapsed_cc_tb;
  localparam int unsigned W = 2;
  localparam int MAXC = (1 << (11 + (1 << W))) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic act = 1'b0, rec = 1'b0, clr = 1'b0;
  logic [11:0] ccm;
  logic [3:0]  cce;
  logic        ccv;

  int n_chk = 0, n_bad = 0;
  int m_cnt = 0;
  bit m_ccv = 0;
  bit done = 0;

  always #4 clk = ~clk;

  elapsed_cc #(.CCE_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .active_i(act), .record_i(rec), .clear_i(clr),
    .ccm_o(ccm), .cce_o(cce), .ccv_o(ccv)
  );

  function automatic void enc(input int c, output int m, output int e);
    int p;
    if (c < 4096) begin
      m = c; e = 0;
    end else begin
      p = 0;
      while ((c >> (p + 1)) != 0) p++;
      e = p - 11;
      m = (c >> (e - 1)) % 4096;
    end
  endfunction

  task automatic check(input string tag, input int got, input int exp, input string what);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic compare(input string tag);
    int m, e;
    enc(m_cnt, m, e);
    check(tag, int'(ccm), m, "ccm");
    check(tag, int'(cce), e, "cce");
    check(tag, int'(ccv), int'(m_ccv), "ccv");
    check("R5", int'(cce[3:W]), 0, "upper exponent bits");
  endtask

  // one clock: drive at negedge, compare, advance model at posedge
  task automatic cyc(input bit a, input bit r, input bit c, input string tag);
    act = a; rec = r; clr = c;
    #2;
    compare(tag);
    @(posedge clk);
    if (c) begin
      m_cnt = 0; m_ccv = 0;
    end else if (r) begin
      m_cnt = a ? 1 : 0; m_ccv = 1;
    end else if (a && m_cnt < MAXC) begin
      m_cnt++;
    end
    @(negedge clk);
  endtask

  task automatic run(input int n, input bit a, input string tag);
    for (int i = 0; i < n; i++) cyc(a, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    #2;
    check("R9", int'(ccm), 0, "ccm in reset");
    check("R9", int'(cce), 0, "cce in reset");
    check("R9", int'(ccv), 0, "ccv in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: counting with gaps
    run(10, 1, "R1");
    run(5, 0, "R1");
    for (int i = 0; i < 20; i++) cyc(i % 3 != 0, 1'b0, 1'b0, "R1");
    // R6/R8: first record after reset carries ccv 0, record cycle inactive
    cyc(1'b0, 1'b1, 1'b0, "R6");
    run(7, 1, "R2");
    // R6: record on an active cycle opens next interval at 1
    cyc(1'b1, 1'b1, 1'b0, "R6");
    run(3, 1, "R8");
    cyc(1'b0, 1'b1, 1'b0, "R8");
    // R7: clear with active high, then record with ccv 0
    run(4, 1, "R7");
    cyc(1'b1, 1'b0, 1'b1, "R7");
    run(2, 0, "R7");
    cyc(1'b0, 1'b1, 1'b0, "R8");
    // R7: clear and record together
    run(6, 1, "R7");
    cyc(1'b1, 1'b1, 1'b1, "R7");
    cyc(1'b0, 1'b0, 1'b0, "R8");
    // R2/R3: across 4096 and into higher exponents
    run(4100, 1, "R3");
    cyc(1'b0, 1'b1, 1'b0, "R3");
    run(9000, 1, "R3");
    run(20, 0, "R3");
    run(9000, 1, "R3");
    cyc(1'b1, 1'b1, 1'b0, "R3");
    // R4: drive to saturation and beyond
    run(MAXC + 50, 1, "R4");
    check("R4", int'(ccm), 4095, "saturated ccm");
    check("R4", int'(cce), (1 << W) - 1, "saturated cce");
    cyc(1'b0, 1'b1, 1'b0, "R4");
    run(3, 1, "R6");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule